// File: doc/BRIEF.md
# Serial Channel Loop-Back Steering Unit

This unit sits between a serial channel's shift engines and its two line pins. It steers the bit stream, chooses the clock that drives the receiver and gates the processor-side handshakes. Three modes are available. In normal operation, the pins connect straight through. In internal loop-back, the transmitter's bit stream returns to the receiver inside the chip and the line stays idle. In line echo, every bit that arrives on the input pin goes straight back out on the output pin, and the processor can no longer load the transmitter.

Software asks for a mode on `mode_req`. The unit adopts a request only while the transmitter reports no character in flight, so a frame that is being shifted out is never cut in two. The mode that is in force can be read on `mode_act`. A sticky flag records that the processor tried to load the transmitter while line echo was in force.

Top module: `serloop_mux`

## Requirements
- R1: Mode codes on `mode_req`/`mode_act` are 2'b00 normal, 2'b01 internal loop-back and 2'b10 line echo. In normal mode, `txd_pin` follows `tx_ser`, `rx_ser` follows `rxd_pin` and `rx_clk_out` follows `rx_clk`.
- R2: In internal loop-back, `rx_ser` follows `tx_ser` and the value on `rxd_pin` has no effect on any output.
- R3: In internal loop-back, `txd_pin` is held at 1, the idle mark level.
- R4: In internal loop-back, `rx_clk_out` follows `tx_clk`.
- R5: In internal loop-back, `tx_run` is 1 whatever `tx_enable` is, and `rx_run` equals `rx_enable`. In the other modes, `tx_run` equals `tx_enable`.
- R6: In normal mode and internal loop-back, `tx_wr_en` equals `cpu_tx_wr` and `rx_rd_en` equals `cpu_rx_rd`.
- R7: In line echo, `txd_pin` follows `rxd_pin` bit for bit. The receiver keeps taking `rxd_pin` on `rx_clk`.
- R8: In line echo, `tx_wr_en` is always 0, while `rx_rd_en` still equals `cpu_rx_rd`.
- R9: A `cpu_tx_wr` pulse seen at a clock edge while line echo is in force sets `wr_dropped` from the next cycle on. The flag stays set until the active mode changes, and it reads 0 from the cycle in which the new mode is active.
- R10: A request on `mode_req` that differs from `mode_act` is taken at a clock edge only while `tx_busy` is 0. It is then visible on `mode_act` one cycle later. While `tx_busy` is 1, `mode_act` does not change.
- R11: The code 2'b11 on `mode_req` is ignored, and `mode_act` keeps its value.
- R12: While `rst_n` is low, `mode_act` is 2'b00 and `wr_dropped` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_req | input | 2 | Requested mode code |
| tx_busy | input | 1 | Transmitter has a character in flight |
| tx_enable | input | 1 | Software enable for the transmitter |
| rx_enable | input | 1 | Software enable for the receiver |
| tx_ser | input | 1 | Serial output of the transmitter |
| tx_clk | input | 1 | Transmitter bit clock |
| rx_clk | input | 1 | Receiver's own bit clock |
| rxd_pin | input | 1 | External receive line |
| cpu_tx_wr | input | 1 | Processor write strobe toward the transmitter |
| cpu_rx_rd | input | 1 | Processor read strobe from the receiver |
| txd_pin | output | 1 | External transmit line |
| rx_ser | output | 1 | Serial input to the receiver |
| rx_clk_out | output | 1 | Bit clock delivered to the receiver |
| tx_wr_en | output | 1 | Gated write strobe to the transmitter |
| rx_rd_en | output | 1 | Gated read strobe from the receiver |
| tx_run | output | 1 | Effective transmitter enable |
| rx_run | output | 1 | Effective receiver enable |
| mode_act | output | 2 | Mode currently in force |
| wr_dropped | output | 1 | Sticky flag for a write discarded in line echo |

## Verification
The hardest case to reach is a mode request that arrives while a character is in flight. Holding `tx_busy` high must keep the old steering in place for as long as it lasts, and the switch must then happen on the first idle edge. The stimulus holds `tx_busy` high across several edges with a new request pending. It checks that `mode_act` has not moved, then drops `tx_busy` and expects the change exactly one cycle later. The same approach covers the dropped-write flag: a write is issued in line echo, and the flag must then survive until a mode change is actually accepted.

// File: rtl/serloop_mux.sv
module serloop_mux #(
  parameter logic [1:0] MODE_NORMAL = 2'b00,
  parameter logic [1:0] MODE_LOCAL  = 2'b01,
  parameter logic [1:0] MODE_ECHO   = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       tx_busy,
  input  logic       tx_enable,
  input  logic       rx_enable,
  input  logic       tx_ser,
  input  logic       tx_clk,
  input  logic       rx_clk,
  input  logic       rxd_pin,
  input  logic       cpu_tx_wr,
  input  logic       cpu_rx_rd,
  output logic       txd_pin,
  output logic       rx_ser,
  output logic       rx_clk_out,
  output logic       tx_wr_en,
  output logic       rx_rd_en,
  output logic       tx_run,
  output logic       rx_run,
  output logic [1:0] mode_act,
  output logic       wr_dropped
);

  logic req_valid, take_req, is_local, is_echo;

  assign req_valid = (mode_req == MODE_NORMAL) || (mode_req == MODE_LOCAL) ||
                     (mode_req == MODE_ECHO);
  assign take_req  = req_valid && !tx_busy && (mode_req != mode_act);
  assign is_local  = (mode_act == MODE_LOCAL);
  assign is_echo   = (mode_act == MODE_ECHO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_act <= MODE_NORMAL;
    else if (take_req) mode_act <= mode_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wr_dropped <= 1'b0;
    else if (take_req)              wr_dropped <= 1'b0;
    else if (is_echo && cpu_tx_wr)  wr_dropped <= 1'b1;
  end

  always_comb begin
    txd_pin = tx_ser;
    rx_ser  = rxd_pin;
    if (is_local) begin
      txd_pin = 1'b1;
      rx_ser  = tx_ser;
    end else if (is_echo) begin
      txd_pin = rxd_pin;
    end
  end

  assign rx_clk_out = is_local ? tx_clk : rx_clk;
  assign tx_wr_en   = cpu_tx_wr && !is_echo;
  assign rx_rd_en   = cpu_rx_rd;
  assign tx_run     = tx_enable || is_local;
  assign rx_run     = rx_enable;

endmodule

// File: rtl/serloop_mux_chk.sv
module serloop_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_act,
  input logic       tx_busy,
  input logic       cpu_tx_wr,
  input logic       tx_wr_en,
  input logic       wr_dropped,
  input logic       txd_pin,
  input logic       rx_ser,
  input logic       tx_ser,
  input logic       rxd_pin,
  input logic       tx_run
);

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable(mode_act));

  p_mark_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'b01) |-> txd_pin);

  p_loop_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'b01) |-> (rx_ser == tx_ser));

  p_echo_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'b10) |-> (txd_pin == rxd_pin));

  p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'b10) |-> !tx_wr_en);

  p_drop_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'b10 && cpu_tx_wr) |=> (wr_dropped || mode_act != 2'b10));

  p_tx_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'b01) |-> tx_run);

  p_legal_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_act != 2'b11);

endmodule

bind serloop_mux serloop_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_act(mode_act), .tx_busy(tx_busy),
  .cpu_tx_wr(cpu_tx_wr), .tx_wr_en(tx_wr_en), .wr_dropped(wr_dropped),
  .txd_pin(txd_pin), .rx_ser(rx_ser), .tx_ser(tx_ser), .rxd_pin(rxd_pin),
  .tx_run(tx_run)
);

// File: tb/sim_serloop_mux.sv
module sim_serloop_mux;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic tx_busy = 1'b0, tx_enable = 1'b0, rx_enable = 1'b0;
  logic tx_ser = 1'b1, tx_clk = 1'b0, rx_clk = 1'b0, rxd_pin = 1'b1;
  logic cpu_tx_wr = 1'b0, cpu_rx_rd = 1'b0;
  logic txd_pin, rx_ser, rx_clk_out, tx_wr_en, rx_rd_en, tx_run, rx_run, wr_dropped;
  logic [1:0] mode_act;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serloop_mux u0 (.*);

  // {mode, tx_ser, rxd, tx_clk, rx_clk, wr, rd, tx_en, rx_en} -> {txd, rx_ser, rx_clk_out, wr_en, rd_en, tx_run, rx_run}
  localparam logic [16:0] VEC [7] = '{
    17'b00_1_0_0_1_1_0_1_0__1_0_1_1_0_1_0,
    17'b00_0_1_1_0_0_1_0_1__0_1_0_0_1_0_1,
    17'b01_0_1_1_0_1_1_0_0__1_0_1_1_1_1_0,
    17'b01_1_0_0_1_0_0_1_1__1_1_0_0_0_1_1,
    17'b01_0_0_0_1_0_1_0_1__1_0_0_0_1_1_1,
    17'b10_0_1_0_1_1_1_1_1__1_1_1_0_1_1_1,
    17'b10_1_0_1_0_0_0_0_0__0_0_0_0_0_0_0
  };

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_mode(input logic [1:0] m);
    tx_busy = 1'b0;
    mode_req = m;
    tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R12 reset", {5'b0, mode_act}, 7'b0);
    chk("R12 reset flag", {6'b0, wr_dropped}, 7'b0);
    tick();
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 7; i++) begin
      logic [16:0] v;
      v = VEC[i];
      go_mode(v[16:15]);
      {tx_ser, rxd_pin, tx_clk, rx_clk, cpu_tx_wr, cpu_rx_rd, tx_enable, rx_enable} = v[14:7];
      #1;
      chk(v[16:15] == 2'b00 ? "R1 R5 R6 normal" :
          v[16:15] == 2'b01 ? "R2 R3 R4 R5 R6 local" : "R7 R8 R5 echo",
          {txd_pin, rx_ser, rx_clk_out, tx_wr_en, rx_rd_en, tx_run, rx_run}, v[6:0]);
      cpu_tx_wr = 1'b0;
      cpu_rx_rd = 1'b0;
    end

    go_mode(2'b00);
    chk("R10 back to normal", {5'b0, mode_act}, 7'd0);
    chk("R9 cleared on change", {6'b0, wr_dropped}, 7'd0);

    tx_busy = 1'b1;
    mode_req = 2'b01;
    tick(); tick(); tick();
    chk("R10 held while busy", {5'b0, mode_act}, 7'd0);
    tx_busy = 1'b0;
    tick();
    chk("R10 taken when idle", {5'b0, mode_act}, 7'd1);

    mode_req = 2'b11;
    tick(); tick();
    chk("R11 code 3 ignored", {5'b0, mode_act}, 7'd1);

    // R2: stream through internal loop-back with rxd opposite
    for (int b = 0; b < 8; b++) begin
      tx_ser = b[0] ^ b[2];
      rxd_pin = ~tx_ser;
      #1;
      chk("R2 R3 loop stream", {5'b0, rx_ser, txd_pin}, {5'b0, tx_ser, 1'b1});
      tick();
    end

    go_mode(2'b10);
    chk("R9 no flag before write", {6'b0, wr_dropped}, 7'd0);
    cpu_tx_wr = 1'b1;
    #1;
    chk("R8 write blocked", {6'b0, tx_wr_en}, 7'd0);
    tick();
    cpu_tx_wr = 1'b0;
    chk("R9 flag set", {6'b0, wr_dropped}, 7'd1);
    tick(); tick();
    chk("R9 flag sticky", {6'b0, wr_dropped}, 7'd1);

    tx_busy = 1'b1;
    mode_req = 2'b00;
    tick();
    chk("R9 R10 flag kept while busy", {4'b0, wr_dropped, mode_act}, {4'b0, 1'b1, 2'b10});
    for (int b = 0; b < 4; b++) begin
      rxd_pin = b[0];
      #1;
      chk("R7 echo stream", {6'b0, txd_pin}, {6'b0, b[0]});
      tick();
    end
    tx_busy = 1'b0;
    tick();
    chk("R9 flag cleared", {4'b0, wr_dropped, mode_act}, 7'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule